// File: doc/BRIEF.md
# Dual-Role Serial Data and Divider Register

This block holds the 16-bit data word of one serial channel, and the meaning of its upper seven bits depends on the channel's run state. While the channel is stopped, bits [15:9] are the transfer-clock divider setting and the lower nine bits must stay zero. While the channel runs, the whole word is the transmit/receive buffer. The divider value in use is captured when the channel starts, so buffer traffic in the upper bits cannot disturb the transfer clock.

The block turns the master clock into a one-cycle transfer tick every (N+1) cycles, where N is the divider field. A source select can instead pass an external tick straight through. Software writes the register with a 16-bit strobe, or with an 8-bit strobe that reaches the low byte only. A low-byte write made while the channel is stopped wipes the divider field. One error output flags divider values that the selected protocol mode forbids, and it also flags writes that break the stopped-state rules.

Top module: `serial_dual_reg`

## Requirements
- R1: After reset, reg_q is 0x0000, tick is 0 and, with mode 2'b00, cfg_err is 0.
- R2: A word write (wr_word=1) stores all 16 bits of wr_data, visible on reg_q in the next cycle, whether the channel is stopped or running. When wr_word and wr_byte are both high, the word write wins.
- R3: A byte write (wr_byte=1, wr_word=0) while run_en=1 replaces reg_q[7:0] only, and reg_q[15:8] keep their value.
- R4: A byte write while run_en=0 replaces reg_q[7:0], clears reg_q[15:9], keeps reg_q[8] and raises cfg_err from the next cycle.
- R5: With src_sel=0 and divider value N, the cycle in which run_en first reads 1 is cycle 0. tick is high in cycles N, 2N+1, 3N+2 and so on, one pulse every N+1 cycles, and low in every other cycle.
- R6: The divider in use while running is reg_q[15:9] as held in the cycle where run_en rises. A word write in that same cycle, or any later write while running, does not change the tick period.
- R7: tick is 0 whenever run_en is 0, for either src_sel value.
- R8: With src_sel=1 and run_en=1, tick equals ext_tick in the same cycle.
- R9: The divider value in use is illegal when mode is 2'b01 (UART) and N is 0 or 1, or when mode is 2'b10 (simple I2C) and N is 0. Modes 2'b00 and 2'b11 accept every value. An illegal value drives cfg_err high. While stopped, the value in use is reg_q[15:9]. While running, it is the captured value.
- R10: A stopped word write with any of wr_data[8:0] nonzero is stored unchanged and raises cfg_err from the next cycle. The flag stays set until a stopped word write with wr_data[8:0] all zero. Writes made while running leave the flag alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master operating clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Channel run (1) / stop (0) |
| src_sel | input | 1 | 0: internal divider, 1: pass ext_tick |
| mode | input | 2 | 00 other, 01 UART, 10 simple I2C, 11 other |
| wr_word | input | 1 | 16-bit write strobe |
| wr_byte | input | 1 | 8-bit write strobe for bits [7:0] |
| wr_data | input | 16 | Write data |
| ext_tick | input | 1 | External transfer-clock enable |
| reg_q | output | 16 | Current register contents |
| tick | output | 1 | Transfer-clock enable pulse |
| cfg_err | output | 1 | Illegal divider or illegal stopped write |

## Verification
Two functions can fall in the same cycle: the capture of the divider when run_en rises, and a CPU word write that lands in that cycle and puts new bits into [15:9]. The bench makes them coincide by asserting run_en and wr_word in the same cycle with a different field value. It then measures the tick train and requires the period of the value held before the write, while reg_q shows the newly written word. The bench also raises both write strobes together and checks that the stored word carries an intact upper field, which would not be the case if the byte path had won.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

  typedef enum logic [1:0] {
    SDR_MODE_OTHER = 2'b00,
    SDR_MODE_UART  = 2'b01,
    SDR_MODE_I2C   = 2'b10,
    SDR_MODE_SPARE = 2'b11
  } sdr_mode_e;

  // Lowest legal divider value for a protocol mode.
  function automatic logic [31:0] div_floor(input logic [1:0] mode);
    case (mode)
      SDR_MODE_UART: div_floor = 32'd2;
      SDR_MODE_I2C:  div_floor = 32'd1;
      default:       div_floor = 32'd0;
    endcase
  endfunction

  function automatic logic div_is_illegal(input logic [1:0] mode,
                                          input logic [31:0] div);
    div_is_illegal = (div < div_floor(mode));
  endfunction

  // Master cycles per transfer tick for a divider field value.
  function automatic logic [31:0] div_period(input logic [31:0] div);
    div_period = div + 32'd1;
  endfunction

endpackage

// File: rtl/sdr_store.sv
module sdr_store #(
  parameter int DATA_W  = 16,
  parameter int DIV_W   = 7,
  parameter int BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              wr_word,
  input  logic              wr_byte,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] reg_q,
  output logic              bad_wr_q,
  output logic              low_viol,
  output logic              stop_byte
);
  localparam int DIV_LSB = DATA_W - DIV_W;

  logic [DATA_W-1:0] reg_d;
  logic              word_stop;

  assign word_stop = wr_word & ~run_en;
  assign low_viol  = word_stop & (|wr_data[DIV_LSB-1:0]);
  assign stop_byte = wr_byte & ~wr_word & ~run_en;

  always_comb begin
    reg_d = reg_q;
    if (wr_word) begin
      reg_d = wr_data;
    end else if (wr_byte) begin
      reg_d[BYTE_W-1:0] = wr_data[BYTE_W-1:0];
      if (!run_en) begin
        reg_d[DATA_W-1:DIV_LSB] = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_q    <= '0;
      bad_wr_q <= 1'b0;
    end else begin
      reg_q <= reg_d;
      if (low_viol || stop_byte) begin
        bad_wr_q <= 1'b1;
      end else if (word_stop) begin
        bad_wr_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sdr_shadow.sv
module sdr_shadow #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [DIV_W-1:0] field_in,
  output logic [DIV_W-1:0] div_cur,
  output logic             run_rise
);
  logic             run_d;
  logic [DIV_W-1:0] shadow_q;

  assign run_rise = run_en & ~run_d;
  // In the rise cycle the field still holds its pre-run value.
  assign div_cur  = (run_en & run_d) ? shadow_q : field_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_d    <= 1'b0;
      shadow_q <= '0;
    end else begin
      run_d <= run_en;
      if (run_rise) begin
        shadow_q <= field_in;
      end
    end
  end

endmodule

// File: rtl/sdr_divider.sv
module sdr_divider #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             src_sel,
  input  logic [DIV_W-1:0] div_cur,
  input  logic             ext_tick,
  output logic             int_hit,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic             count_on;

  assign count_on = run_en & ~src_sel;
  assign int_hit  = count_on & (cnt_q == div_cur);
  assign tick     = run_en & (src_sel ? ext_tick : int_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!count_on || int_hit) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/serial_dual_reg.sv
module serial_dual_reg
  import sdr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 7,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              src_sel,
  input  logic [1:0]        mode,
  input  logic              wr_word,
  input  logic              wr_byte,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ext_tick,
  output logic [DATA_W-1:0] reg_q,
  output logic              tick,
  output logic              cfg_err
);
  localparam int DIV_LSB = DATA_W - DIV_W;

  logic             bad_wr_q;
  logic             low_viol;
  logic             stop_byte;
  logic [DIV_W-1:0] div_cur;
  logic             run_rise;
  logic             int_hit;
  logic             div_bad;

  sdr_store #(.DATA_W(DATA_W), .DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .wr_word(wr_word), .wr_byte(wr_byte), .wr_data(wr_data),
    .reg_q(reg_q), .bad_wr_q(bad_wr_q),
    .low_viol(low_viol), .stop_byte(stop_byte)
  );

  sdr_shadow #(.DIV_W(DIV_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .field_in(reg_q[DATA_W-1:DIV_LSB]),
    .div_cur(div_cur), .run_rise(run_rise)
  );

  sdr_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .src_sel(src_sel),
    .div_cur(div_cur), .ext_tick(ext_tick),
    .int_hit(int_hit), .tick(tick)
  );

  assign div_bad = div_is_illegal(mode, 32'(div_cur));
  assign cfg_err = div_bad | bad_wr_q;

endmodule

// File: rtl/sdr_checker.sv
module sdr_checker
  import sdr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 7,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_en,
  input logic              src_sel,
  input logic [1:0]        mode,
  input logic              wr_word,
  input logic              wr_byte,
  input logic [DATA_W-1:0] wr_data,
  input logic              ext_tick,
  input logic [DATA_W-1:0] reg_q,
  input logic              tick,
  input logic              cfg_err,
  input logic [DIV_W-1:0]  div_cur,
  input logic              int_hit
);
  localparam int DIV_LSB = DATA_W - DIV_W;

  AST_WORD_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_word |=> reg_q == $past(wr_data)); // R2

  AST_RUN_BYTE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_byte && !wr_word && run_en) |=>
      reg_q[DATA_W-1:BYTE_W] == $past(reg_q[DATA_W-1:BYTE_W])); // R3

  AST_STOP_BYTE_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_byte && !wr_word && !run_en) |=>
      (reg_q[DATA_W-1:DIV_LSB] == '0) && cfg_err); // R4

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (int_hit && div_cur != '0) |=> !int_hit); // R5

  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && $past(run_en)) |-> div_cur == $past(div_cur)); // R6

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !tick); // R7

  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && src_sel) |-> tick == ext_tick); // R8

  AST_UART_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SDR_MODE_UART && div_cur < 2) |-> cfg_err); // R9

  AST_LOW_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word && !run_en && wr_data[DIV_LSB-1:0] != '0) |=> cfg_err); // R10

endmodule

bind serial_dual_reg sdr_checker #(.DATA_W(DATA_W), .DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .src_sel(src_sel), .mode(mode),
  .wr_word(wr_word), .wr_byte(wr_byte), .wr_data(wr_data), .ext_tick(ext_tick),
  .reg_q(reg_q), .tick(tick), .cfg_err(cfg_err),
  .div_cur(div_cur), .int_hit(int_hit)
);

// File: tb/serial_dual_reg_bench.sv
module serial_dual_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        src_sel = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        wr_word = 1'b0;
  logic        wr_byte = 1'b0;
  logic [15:0] wr_data = '0;
  logic        ext_tick = 1'b0;
  logic [15:0] reg_q;
  logic        tick;
  logic        cfg_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serial_dual_reg u_serial_dual_reg (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .src_sel(src_sel), .mode(mode),
    .wr_word(wr_word), .wr_byte(wr_byte), .wr_data(wr_data), .ext_tick(ext_tick),
    .reg_q(reg_q), .tick(tick), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic write_word(input logic [15:0] d);
    wr_word = 1'b1; wr_data = d;
    step();
    wr_word = 1'b0;
    #2;
  endtask

  task automatic write_byte(input logic [15:0] d);
    wr_byte = 1'b1; wr_data = d;
    step();
    wr_byte = 1'b0;
    #2;
  endtask

  // Expected error from the mode rules, stated independently.
  function automatic bit exp_illegal(input logic [1:0] m, input int v);
    if (m == 2'b01) return (v == 0) || (v == 1);
    if (m == 2'b10) return (v == 0);
    return 1'b0;
  endfunction

  // Runs 3*(n+1) cycles from the enable rise; optional word write at cycle wr_at.
  task automatic run_and_count(input int n, input int wr_at, input logic [15:0] wd,
                               output int bad);
    bad = 0;
    step();
    run_en = 1'b1;
    for (int c = 0; c < 3 * (n + 1); c++) begin
      wr_word = (c == wr_at);
      wr_data = wd;
      #2;
      if (tick !== ((c % (n + 1)) == n)) bad++;
      step();
    end
    wr_word = 1'b0;
    run_en = 1'b0;
    step();
    #2;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int bad;
    repeat (3) step();
    rst_n = 1'b1;
    #2;
    chk(reg_q == 16'h0000, "R1", "reset reg_q", reg_q, 0);
    chk(tick == 1'b0, "R1", "reset tick", tick, 0);
    chk(cfg_err == 1'b0, "R1", "reset cfg_err", cfg_err, 0);

    // R7: stopped, internal source, no tick for several cycles.
    bad = 0;
    for (int c = 0; c < 10; c++) begin step(); #2; if (tick) bad++; end
    chk(bad == 0, "R7", "stopped tick count", bad, 0);

    // R5: every divider value, full tick train.
    step();
    for (int n = 0; n < 128; n++) begin
      write_word({n[6:0], 9'd0});
      chk(reg_q == {n[6:0], 9'd0}, "R2", "word store", reg_q, {n[6:0], 9'd0});
      run_and_count(n, -1, 16'h0000, bad);
      chk(bad == 0, "R5", $sformatf("tick train N=%0d mismatches", n), bad, 0);
    end

    // R9: every mode and divider value while stopped.
    for (int m = 0; m < 4; m++) begin
      mode = m[1:0];
      for (int v = 0; v < 128; v++) begin
        step();
        write_word({v[6:0], 9'd0});
        chk(cfg_err == exp_illegal(m[1:0], v), "R9",
            $sformatf("mode=%0d N=%0d cfg_err", m, v), cfg_err, exp_illegal(m[1:0], v));
      end
    end
    mode = 2'b00;

    // R10: low-bit rule.
    step(); write_word(16'h0A01);
    chk(reg_q == 16'h0A01, "R10", "violating word stored", reg_q, 16'h0A01);
    chk(cfg_err == 1'b1, "R10", "low-bit violation flag", cfg_err, 1);
    step(); #2;
    chk(cfg_err == 1'b1, "R10", "flag held", cfg_err, 1);
    step(); write_word(16'h0A00);
    chk(cfg_err == 1'b0, "R10", "flag cleared by clean write", cfg_err, 0);

    // R4: stopped byte write wipes field, keeps bit 8.
    step(); write_word(16'hFF00);
    step(); write_byte(16'h33A5);
    chk(reg_q == 16'h01A5, "R4", "stopped byte result", reg_q, 16'h01A5);
    chk(cfg_err == 1'b1, "R4", "stopped byte flag", cfg_err, 1);
    step(); write_word(16'hFE00);
    chk(cfg_err == 1'b0, "R4", "flag cleared", cfg_err, 0);

    // R2: simultaneous word and byte, word wins.
    step();
    wr_word = 1'b1; wr_byte = 1'b1; wr_data = 16'h2400;
    step(); wr_word = 1'b0; wr_byte = 1'b0; #2;
    chk(reg_q == 16'h2400, "R2", "word beats byte", reg_q, 16'h2400);

    // R3: running byte write.
    step(); write_word(16'h0600);
    step(); run_en = 1'b1;
    step(); write_byte(16'hFF5A);
    chk(reg_q == 16'h065A, "R3", "running byte result", reg_q, 16'h065A);
    chk(cfg_err == 1'b0, "R3", "running byte no flag", cfg_err, 0);
    step(); run_en = 1'b0; step();

    // R6: word write in the rise cycle, then mid-run writes.
    write_word({7'd3, 9'd0});
    run_and_count(3, 0, {7'd10, 9'd0}, bad);
    chk(bad == 0, "R6", "rise-cycle write keeps period", bad, 0);
    chk(reg_q == {7'd10, 9'd0}, "R6", "rise-cycle write stored", reg_q, {7'd10, 9'd0});
    step(); write_word({7'd5, 9'd0});
    run_and_count(5, 7, 16'h0001, bad);
    chk(bad == 0, "R6", "mid-run write keeps period", bad, 0);

    // R9 while running: the captured value governs.
    mode = 2'b01;
    step(); write_word({7'd5, 9'd0});
    step(); run_en = 1'b1;
    step(); write_word(16'h0000);
    chk(cfg_err == 1'b0, "R9", "running uses captured value", cfg_err, 0);
    chk(reg_q == 16'h0000, "R2", "running word store", reg_q, 0);
    run_en = 1'b0; #2;
    chk(cfg_err == 1'b1, "R9", "stopped field 0 in UART", cfg_err, 1);
    mode = 2'b00;

    // R8: bypass, then R7 with bypass selected but stopped.
    step(); src_sel = 1'b1; run_en = 1'b1;
    bad = 0;
    for (int c = 0; c < 24; c++) begin
      step(); ext_tick = (c % 3 == 1); #2;
      if (tick !== ext_tick) bad++;
    end
    chk(bad == 0, "R8", "bypass mismatches", bad, 0);
    step(); run_en = 1'b0; ext_tick = 1'b1; #2;
    chk(tick == 1'b0, "R7", "stopped with bypass", tick, 0);
    step(); ext_tick = 1'b0; src_sel = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule